// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block joins two 8-bit buses, called A and B, through two one-way paths. The A-to-B path carries data from port A toward port B, and the B-to-A path carries data from port B toward port A. Each path has its own holding register with its own clock, and its own source selector. The selector decides whether the driven port shows the opposite bus live, through a purely combinational path, or shows the value last captured in that path's register.

An active-low output enable and a direction input together pick which port is driven, if either is. The two ports are never driven together. The register clocks have no link to the enable or direction inputs. Each register samples its source port on every rising edge of its own clock, whichever way the bus is facing, so a port that is currently being driven, or is idle, can still be captured. Each bidirectional port is modelled as three vectors: a pin input, a pin output value and a per-bit output enable.

Top module: `dual_path_xcvr`

## Requirements
- R1: When `oe_n` is 1, `a_oe` and `b_oe` are all zeros, and `a_out` and `b_out` are zero.
- R2: When `oe_n` is 0 and `dir_a2b` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R3: When `oe_n` is 0 and `dir_a2b` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R4: `a_oe` and `b_oe` never have set bits at the same time.
- R5: While port B is driven, `b_out` equals `a_in` in the same cycle when `ab_src` is 0 (live), and equals the A-to-B register when `ab_src` is 1 (held).
- R6: While port A is driven, `a_out` equals `b_in` in the same cycle when `ba_src` is 0 (live), and equals the B-to-A register when `ba_src` is 1 (held).
- R7: On each rising edge of `ab_clk` the A-to-B register loads `a_in`, whatever the values of `oe_n` and `dir_a2b`, including while port A is being driven.
- R8: On each rising edge of `ba_clk` the B-to-A register loads `b_in`, whatever the values of `oe_n` and `dir_a2b`, including while port B is being driven.
- R9: An edge on one path's clock leaves the other path's register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ab_clk | input | 1 | Capture clock of the A-to-B register (rising edge) |
| ba_clk | input | 1 | Capture clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Output enable, active low |
| dir_a2b | input | 1 | 1: drive port B from the A-to-B path; 0: drive port A from the B-to-A path |
| ab_src | input | 1 | A-to-B source: 0 live from port A, 1 held register |
| ba_src | input | 1 | B-to-A source: 0 live from port B, 1 held register |
| a_in | input | 8 | Values seen on port A pins |
| a_out | output | 8 | Value driven onto port A |
| a_oe | output | 8 | Per-bit drive enable of port A |
| b_in | input | 8 | Values seen on port B pins |
| b_out | output | 8 | Value driven onto port B |
| b_oe | output | 8 | Per-bit drive enable of port B |

## Verification
Capture into a register and driving of a port can fall in the same cycle, because the clocks ignore the enable and direction inputs. The bench provokes this by pulsing one path's clock while the outputs are disabled, and again while the opposite port is being driven. After the pulse it turns the bus around and selects the held source, then judges whether the driven port shows the value that was on the pin at the capture edge. A separate case pulses only one clock after loading both registers, and checks that the other path still shows its older value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XW_DEFAULT = 8;
    localparam int unsigned NPATH      = 2;
    localparam int unsigned P_AB       = 0;
    localparam int unsigned P_BA       = 1;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
    } drive_t;

    function automatic drive_t decode_drive(input logic oe_n, input logic a2b);
        drive_t d;
        d.drv_a = ~oe_n & ~a2b;
        d.drv_b = ~oe_n &  a2b;
        return d;
    endfunction

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_e         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_HELD: y = held;
            default:  y = live;
        endcase
    end
endmodule

// File: rtl/xcvr_port_drv.sv
module xcvr_port_drv #(
    parameter int unsigned W = 8
) (
    input  logic         en,
    input  logic [W-1:0] val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    assign pin_oe  = {W{en}};
    assign pin_out = en ? val : '0;
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XW_DEFAULT
) (
    input  logic         ab_clk,
    input  logic         ba_clk,
    input  logic         oe_n,
    input  logic         dir_a2b,
    input  logic         ab_src,
    input  logic         ba_src,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [NPATH-1:0] path_clk;
    logic [NPATH-1:0] path_sel;
    logic [W-1:0]     path_src  [NPATH];
    logic [W-1:0]     path_held [NPATH];
    logic [W-1:0]     path_val  [NPATH];
    drive_t           drv;

    assign path_clk[P_AB] = ab_clk;
    assign path_clk[P_BA] = ba_clk;
    assign path_sel[P_AB] = ab_src;
    assign path_sel[P_BA] = ba_src;
    assign path_src[P_AB] = a_in;
    assign path_src[P_BA] = b_in;

    assign drv = decode_drive(oe_n, dir_a2b);

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        xcvr_hold_reg #(.W(W)) u_hold (
            .clk (path_clk[p]),
            .d   (path_src[p]),
            .q   (path_held[p])
        );
        xcvr_src_mux #(.W(W)) u_mux (
            .sel  (src_e'(path_sel[p])),
            .live (path_src[p]),
            .held (path_held[p]),
            .y    (path_val[p])
        );
    end

    xcvr_port_drv #(.W(W)) u_drv_a (
        .en      (drv.drv_a),
        .val     (path_val[P_BA]),
        .pin_out (a_out),
        .pin_oe  (a_oe)
    );

    xcvr_port_drv #(.W(W)) u_drv_b (
        .en      (drv.drv_b),
        .val     (path_val[P_AB]),
        .pin_out (b_out),
        .pin_oe  (b_oe)
    );
endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
    parameter int unsigned W = 8
) (
    input logic         ab_clk,
    input logic         ba_clk,
    input logic         oe_n,
    input logic         dir_a2b,
    input logic         ab_src,
    input logic         ba_src,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);
    logic ab_primed = 1'b0;
    logic ba_primed = 1'b0;

    always_ff @(posedge ab_clk) ab_primed <= 1'b1;
    always_ff @(posedge ba_clk) ba_primed <= 1'b1;

    // R1
    p_idle_quiet_r1: assert property (@(posedge ab_clk) disable iff (!ab_primed)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R2
    p_drive_b_r2: assert property (@(posedge ab_clk) disable iff (!ab_primed)
        (!oe_n && dir_a2b) |-> (b_oe == '1 && a_oe == '0));

    // R3
    p_drive_a_r3: assert property (@(posedge ba_clk) disable iff (!ba_primed)
        (!oe_n && !dir_a2b) |-> (a_oe == '1 && b_oe == '0));

    // R4
    p_one_side_r4: assert property (@(posedge ab_clk) disable iff (!ab_primed)
        !((|a_oe) && (|b_oe)));

    // R5
    p_ab_live_r5: assert property (@(posedge ab_clk) disable iff (!ab_primed)
        (!oe_n && dir_a2b && !ab_src) |-> (b_out == a_in));

    // R5, R7
    p_ab_held_r7: assert property (@(posedge ab_clk) disable iff (!ab_primed)
        (!oe_n && dir_a2b && ab_src) |-> (b_out == $past(a_in)));

    // R6
    p_ba_live_r6: assert property (@(posedge ba_clk) disable iff (!ba_primed)
        (!oe_n && !dir_a2b && !ba_src) |-> (a_out == b_in));

    // R6, R8
    p_ba_held_r8: assert property (@(posedge ba_clk) disable iff (!ba_primed)
        (!oe_n && !dir_a2b && ba_src) |-> (a_out == $past(b_in)));
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/dual_path_xcvr_bench.sv
`timescale 1ns/1ps
module dual_path_xcvr_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic ab_go = 1'b0, ba_go = 1'b0;
    logic ab_clk, ba_clk;
    logic oe_n = 1'b1, dir_a2b = 1'b0, ab_src = 1'b0, ba_src = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_ab, m_ba;

    always #5 clk = ~clk;
    assign ab_clk = clk & ab_go;
    assign ba_clk = clk & ba_go;

    dual_path_xcvr #(.W(W)) u_dual_path_xcvr (
        .ab_clk(ab_clk), .ba_clk(ba_clk), .oe_n(oe_n), .dir_a2b(dir_a2b),
        .ab_src(ab_src), .ba_src(ba_src),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic expect_eq(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compares all four outputs with values derived from the requirements.
    task automatic check_ports(string tag);
        logic da, db;
        logic [W-1:0] ea, eb;
        #2;
        da = !oe_n && !dir_a2b;
        db = !oe_n && dir_a2b;
        ea = da ? (ba_src ? m_ba : b_in) : '0;
        eb = db ? (ab_src ? m_ab : a_in) : '0;
        expect_eq(tag, "a_oe",  a_oe,  {W{da}});
        expect_eq(tag, "b_oe",  b_oe,  {W{db}});
        expect_eq(tag, "a_out", a_out, ea);
        expect_eq(tag, "b_out", b_out, eb);
    endtask

    task automatic pulse_ab();
        @(negedge clk); ab_go = 1'b1; m_ab = a_in;
        @(negedge clk); ab_go = 1'b0;
    endtask

    task automatic pulse_ba();
        @(negedge clk); ba_go = 1'b1; m_ba = b_in;
        @(negedge clk); ba_go = 1'b0;
    endtask

    task automatic set_ctl(logic o, logic d, logic sa, logic sb);
        @(negedge clk);
        oe_n = o; dir_a2b = d; ab_src = sa; ba_src = sb;
    endtask

    task automatic t_idle_r1();
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        a_in = 8'hA5; b_in = 8'h5A;
        check_ports("R1");
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        check_ports("R1");
    endtask

    task automatic t_live_r5_r6();
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        foreach (pat_list[i]) begin
            a_in = pat_list[i]; b_in = ~pat_list[i];
            check_ports("R2 R4 R5");
        end
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        foreach (pat_list[i]) begin
            b_in = pat_list[i]; a_in = ~pat_list[i];
            check_ports("R3 R4 R6");
        end
    endtask

    logic [W-1:0] pat_list [4] = '{8'h00, 8'hFF, 8'h96, 8'h01};

    task automatic t_capture_idle_r7_r8();
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
        a_in = 8'h3C; b_in = 8'hC3;
        pulse_ab(); pulse_ba();
        a_in = 8'h00; b_in = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check_ports("R7");
        expect_eq("R7", "held A-to-B", b_out, 8'h3C);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        check_ports("R8");
        expect_eq("R8", "held B-to-A", a_out, 8'hC3);
    endtask

    task automatic t_capture_opposite_r7_r8();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        a_in = 8'h6E;
        pulse_ab();
        a_in = 8'h11;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check_ports("R7");
        expect_eq("R7", "captured while A driven", b_out, 8'h6E);
        b_in = 8'hE6;
        pulse_ba();
        b_in = 8'h22;
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check_ports("R8");
        expect_eq("R8", "captured while B driven", a_out, 8'hE6);
    endtask

    task automatic t_independent_r9();
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
        a_in = 8'h11; b_in = 8'h22;
        pulse_ab(); pulse_ba();
        a_in = 8'h5A; b_in = 8'hA5;
        pulse_ab();
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        check_ports("R9");
        expect_eq("R9", "B-to-A kept", a_out, 8'h22);
        a_in = 8'h77; b_in = 8'h88;
        pulse_ba();
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check_ports("R9");
        expect_eq("R9", "A-to-B kept", b_out, 8'h5A);
    endtask

    task automatic t_select_toggle_r5_r6();
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'hF0;
        check_ports("R5");
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check_ports("R5");
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        b_in = 8'h0F;
        check_ports("R6");
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check_ports("R6");
    endtask

    initial begin
        #2;
        check_ports("R1");
        t_idle_r1();
        t_live_r5_r6();
        t_capture_idle_r7_r8();
        t_capture_opposite_r7_r8();
        t_independent_r9();
        t_select_toggle_r5_r6();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule